// File: doc/BRIEF.md
# Word DMA Into Banked Sample RAM

This block copies a run of 16-bit words from a 16 KiB source buffer into one 4 KiB bank of a banked sample RAM. A single strobe carries the word count. The block takes the first source byte address from a source pointer register and the first destination offset from a destination pointer register, and it latches the bank selected at that moment. It then moves one word per clock whenever both memories report ready.

Both pointer registers are updated by the size of the transfer in the cycle the strobe is accepted, so software can chain transfers without rewriting them. The two registers advance by different scalings: the source pointer counts bytes, and the destination register counts 4-byte units. The two streams also wrap at different boundaries: the source wraps at 16 KiB and the destination offset wraps inside its 4 KiB bank. The host may also load either pointer register directly.

Top module: `wdma_bank_copy`

## Requirements
- R1: After reset, busy is low, both pointer registers read zero, and neither src_rd_en nor dst_wr_en is asserted.
- R2: The first source byte address of a transfer is the source pointer with bit 0 cleared and only bits 13..0 kept (pointer AND 0x3FFE).
- R3: The first destination offset is (destination register shifted left by 2) AND 0xFFE. dst_wr_addr is {bank, offset}, where bank is the bank_sel value sampled when the transfer starts. Later changes to bank_sel have no effect on a running transfer.
- R4: Each moved word advances the source byte address by 2, wrapping modulo 16384.
- R5: Each moved word advances the destination offset by 2, wrapping modulo 4096. The bank bits never change inside a transfer.
- R6: When a transfer starts, the source pointer register becomes its old value plus twice the word count, modulo 2^16.
- R7: When a transfer starts, the destination register becomes its old value plus the word count shifted right by 1, modulo 2^16.
- R8: dst_wr_addr is always even. dst_wr_data[7:0] is the low byte of the source word and goes to that even address. dst_wr_data[15:8] is the high byte and goes to the next odd address.
- R9: A word moves in a cycle exactly when busy, src_ready and dst_ready are all high. In that cycle src_rd_en and dst_wr_en are high. In a stalled cycle nothing is written and the addresses hold.
- R10: busy rises in the cycle after an accepted start with a nonzero count. It falls in the cycle after the last word moves. A start with a count of zero never raises busy and produces no writes.
- R11: A start strobe while busy is ignored. Neither pointer register changes, and the running transfer continues at its own addresses.
- R12: A host pointer write takes effect on the next clock. If a host write and an accepted start fall in the same cycle, the start update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transfer start strobe |
| word_cnt | input | 16 | Number of words, sampled with start |
| src_ptr_we | input | 1 | Host load of source pointer |
| src_ptr_wdata | input | 16 | Source pointer load value |
| dst_ptr_we | input | 1 | Host load of destination register |
| dst_ptr_wdata | input | 16 | Destination register load value |
| bank_sel | input | 4 | Currently selected 4 KiB bank |
| src_ptr | output | 16 | Source pointer register |
| dst_ptr | output | 16 | Destination register (4-byte units) |
| busy | output | 1 | Transfer in progress |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 14 | Source byte address (even) |
| src_rd_data | input | 16 | Source word, same-cycle read data |
| src_ready | input | 1 | Source memory can serve a read |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | 16 | Destination byte address {bank, offset} |
| dst_wr_data | output | 16 | Low byte to even address, high byte to odd |
| dst_ready | input | 1 | Destination memory accepts a write |

## Verification
The bench targets the places where the two streams part ways. In one vector the source runs off the top of 16 KiB while the destination runs off the top of its bank. A design that wraps both at the same boundary would write into the wrong bank or read past the buffer. Odd and top-of-range pointer values check the masking and the two different pointer scalings. A count of 1 leaves the destination register unchanged, and a design that rounds the half-count up would move it. A count of zero must leave busy low, and a start during a transfer must not reload anything. Random-looking ready stalls and a change of bank_sel in mid-transfer catch designs that advance while stalled or that follow the live bank input.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  localparam int unsigned DEF_PTR_W  = 16;
  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_SRC_AW = 14;
  localparam int unsigned DEF_OFF_W  = 12;
  localparam int unsigned DEF_BANK_W = 4;
  localparam int unsigned WORD_BYTES = 2;

  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} xfer_phase_e;
endpackage

// File: rtl/wdma_ptr_regs.sv
module wdma_ptr_regs #(
  parameter int unsigned PTR_W = wdma_pkg::DEF_PTR_W,
  parameter int unsigned CNT_W = wdma_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] cnt,
  input  logic             src_we,
  input  logic [PTR_W-1:0] src_wdata,
  input  logic             dst_we,
  input  logic [PTR_W-1:0] dst_wdata,
  output logic [PTR_W-1:0] src_ptr,
  output logic [PTR_W-1:0] dst_ptr
);
  // Source pointer counts bytes: two per word.
  function automatic logic [PTR_W-1:0] src_step(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] twice;
    twice = {n, 1'b0};
    return PTR_W'(twice);
  endfunction

  // Destination register counts 4-byte units: half a unit per word.
  function automatic logic [PTR_W-1:0] dst_step(input logic [CNT_W-1:0] n);
    return PTR_W'(n >> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else if (launch) begin
      src_ptr <= src_ptr + src_step(cnt);
      dst_ptr <= dst_ptr + dst_step(cnt);
    end else begin
      if (src_we) src_ptr <= src_wdata;
      if (dst_we) dst_ptr <= dst_wdata;
    end
  end

  assert_src_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> src_ptr == $past(src_ptr) + PTR_W'({$past(cnt), 1'b0}));
  assert_dst_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> dst_ptr == $past(dst_ptr) + PTR_W'($past(cnt) >> 1));
  assert_host_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we && !launch) |=> src_ptr == $past(src_wdata));
  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !src_we && !dst_we) |=> ($stable(src_ptr) && $stable(dst_ptr)));
endmodule

// File: rtl/wdma_seq.sv
module wdma_seq #(
  parameter int unsigned CNT_W = wdma_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             beat,
  output logic             launch,
  output logic             busy,
  output logic             last_beat
);
  import wdma_pkg::*;

  xfer_phase_e      phase;
  logic [CNT_W-1:0] remaining;

  assign busy      = (phase == PH_RUN);
  assign launch    = start && !busy;
  assign last_beat = beat && (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      remaining <= '0;
    end else if (launch) begin
      remaining <= cnt;
      phase     <= (cnt != '0) ? PH_RUN : PH_IDLE;
    end else if (beat) begin
      remaining <= remaining - CNT_W'(1);
      if (last_beat) phase <= PH_IDLE;
    end
  end

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt == '0) |=> !busy);
  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt != '0) |=> busy);
  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !busy);
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat) |=> (busy && $stable(remaining)));
endmodule

// File: rtl/wdma_addr_gen.sv
module wdma_addr_gen #(
  parameter int unsigned PTR_W  = wdma_pkg::DEF_PTR_W,
  parameter int unsigned SRC_AW = wdma_pkg::DEF_SRC_AW,
  parameter int unsigned OFF_W  = wdma_pkg::DEF_OFF_W,
  parameter int unsigned BANK_W = wdma_pkg::DEF_BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic                    beat,
  input  logic [PTR_W-1:0]        src_ptr,
  input  logic [PTR_W-1:0]        dst_ptr,
  input  logic [BANK_W-1:0]       bank_sel,
  output logic [SRC_AW-1:0]       src_addr,
  output logic [BANK_W+OFF_W-1:0] dst_addr
);
  localparam int unsigned STEP = wdma_pkg::WORD_BYTES;

  // Source: byte pointer, forced even, kept inside the buffer.
  function automatic logic [SRC_AW-1:0] src_first(input logic [PTR_W-1:0] p);
    return p[SRC_AW-1:0] & ~SRC_AW'(1);
  endfunction

  // Destination: register in 4-byte units, scaled to bytes, kept inside the bank.
  function automatic logic [OFF_W-1:0] dst_first(input logic [PTR_W-1:0] r);
    logic [PTR_W+1:0] bytes;
    bytes = {r, 2'b00};
    return bytes[OFF_W-1:0] & ~OFF_W'(1);
  endfunction

  logic [OFF_W-1:0]  dst_off;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_off  <= '0;
      bank_q   <= '0;
    end else if (launch) begin
      src_addr <= src_first(src_ptr);
      dst_off  <= dst_first(dst_ptr);
      bank_q   <= bank_sel;
    end else if (beat) begin
      src_addr <= src_addr + SRC_AW'(STEP);
      dst_off  <= dst_off + OFF_W'(STEP);
    end
  end

  assign dst_addr = {bank_q, dst_off};

  assert_src_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !launch) |=> src_addr == $past(src_addr) + SRC_AW'(STEP));
  assert_dst_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !launch) |=> dst_off == $past(dst_off) + OFF_W'(STEP));
  assert_bank_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(bank_q));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !launch) |=> ($stable(src_addr) && $stable(dst_off)));
endmodule

// File: rtl/wdma_bank_copy.sv
module wdma_bank_copy #(
  parameter int unsigned PTR_W  = wdma_pkg::DEF_PTR_W,
  parameter int unsigned CNT_W  = wdma_pkg::DEF_CNT_W,
  parameter int unsigned SRC_AW = wdma_pkg::DEF_SRC_AW,
  parameter int unsigned OFF_W  = wdma_pkg::DEF_OFF_W,
  parameter int unsigned BANK_W = wdma_pkg::DEF_BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CNT_W-1:0]        word_cnt,
  input  logic                    src_ptr_we,
  input  logic [PTR_W-1:0]        src_ptr_wdata,
  input  logic                    dst_ptr_we,
  input  logic [PTR_W-1:0]        dst_ptr_wdata,
  input  logic [BANK_W-1:0]       bank_sel,
  output logic [PTR_W-1:0]        src_ptr,
  output logic [PTR_W-1:0]        dst_ptr,
  output logic                    busy,
  output logic                    src_rd_en,
  output logic [SRC_AW-1:0]       src_rd_addr,
  input  logic [15:0]             src_rd_data,
  input  logic                    src_ready,
  output logic                    dst_wr_en,
  output logic [BANK_W+OFF_W-1:0] dst_wr_addr,
  output logic [15:0]             dst_wr_data,
  input  logic                    dst_ready
);
  localparam int unsigned LANES = wdma_pkg::WORD_BYTES;

  // Named internal events shared by the sub-blocks and the checks.
  logic launch;
  logic beat;
  logic last_beat;

  assign beat = busy && src_ready && dst_ready;

  wdma_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cnt       (word_cnt),
    .beat      (beat),
    .launch    (launch),
    .busy      (busy),
    .last_beat (last_beat)
  );

  wdma_ptr_regs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .cnt       (word_cnt),
    .src_we    (src_ptr_we),
    .src_wdata (src_ptr_wdata),
    .dst_we    (dst_ptr_we),
    .dst_wdata (dst_ptr_wdata),
    .src_ptr   (src_ptr),
    .dst_ptr   (dst_ptr)
  );

  wdma_addr_gen #(.PTR_W(PTR_W), .SRC_AW(SRC_AW), .OFF_W(OFF_W), .BANK_W(BANK_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .beat     (beat),
    .src_ptr  (src_ptr),
    .dst_ptr  (dst_ptr),
    .bank_sel (bank_sel),
    .src_addr (src_rd_addr),
    .dst_addr (dst_wr_addr)
  );

  assign src_rd_en = beat;
  assign dst_wr_en = beat;

  // Lane k of the write word lands at byte address dst_wr_addr + k.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign dst_wr_data[lane*8 +: 8] = src_rd_data[lane*8 +: 8];
  end

  assert_even_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> !dst_wr_addr[0]);
  assert_write_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> (busy && src_ready && dst_ready && src_rd_en));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dst_wr_en && !src_rd_en));
  assert_last_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !busy);
endmodule

// File: tb/wdma_bank_copy_bench.sv
module wdma_bank_copy_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  localparam logic [15:0] V_SRC [NVEC] = '{16'h0000, 16'h3FFB, 16'hFFFF, 16'h1234, 16'h2222, 16'h8001};
  localparam logic [15:0] V_DST [NVEC] = '{16'h0000, 16'h03FE, 16'hFFFF, 16'h0100, 16'h0005, 16'h1234};
  localparam logic [3:0]  V_BNK [NVEC] = '{4'h0, 4'h7, 4'hF, 4'h3, 4'h5, 4'h9};
  localparam logic [15:0] V_CNT [NVEC] = '{16'd4, 16'd5, 16'd3, 16'd1, 16'd0, 16'd9};
  localparam logic [7:0]  V_SM  [NVEC] = '{8'h00, 8'h00, 8'h24, 8'h00, 8'h00, 8'h5A};
  localparam logic [7:0]  V_DM  [NVEC] = '{8'h00, 8'h00, 8'h81, 8'h02, 8'h00, 8'hC3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] word_cnt = '0;
  logic        src_ptr_we = 1'b0, dst_ptr_we = 1'b0;
  logic [15:0] src_ptr_wdata = '0, dst_ptr_wdata = '0;
  logic [3:0]  bank_sel = '0;
  logic [15:0] src_ptr, dst_ptr;
  logic        busy, src_rd_en, dst_wr_en;
  logic [13:0] src_rd_addr;
  logic [15:0] src_rd_data, dst_wr_addr, dst_wr_data;
  logic        src_ready = 1'b0, dst_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  function automatic logic [15:0] pat(input logic [13:0] a);
    logic [15:0] p;
    p = {2'b00, a} * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  assign src_rd_data = pat(src_rd_addr);

  wdma_bank_copy u_wdma_bank_copy (
    .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt),
    .src_ptr_we(src_ptr_we), .src_ptr_wdata(src_ptr_wdata),
    .dst_ptr_we(dst_ptr_we), .dst_ptr_wdata(dst_ptr_wdata),
    .bank_sel(bank_sel), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .busy(busy),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .src_ready(src_ready), .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr),
    .dst_wr_data(dst_wr_data), .dst_ready(dst_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Walk n words starting at source byte s0, offset o0 in bank bk.
  task automatic run_words(input logic [13:0] s0, input logic [11:0] o0, input logic [3:0] bk,
                           input int n, input logic [7:0] sm, input logic [7:0] dm);
    int done = 0;
    int cyc = 0;
    while (done < n) begin
      src_ready = ~sm[cyc % 8];
      dst_ready = ~dm[cyc % 8];
      #1;
      check(dst_wr_en == (src_ready && dst_ready), "R9 write strobe", dst_wr_en, src_ready && dst_ready);
      if (src_ready && dst_ready) begin
        logic [13:0] sa;
        logic [11:0] oa;
        sa = (s0 + 14'(2*done)) & 14'h3FFF;
        oa = (o0 + 12'(2*done)) & 12'hFFF;
        check(src_rd_addr == sa && src_rd_en, "R4 source address", src_rd_addr, sa);
        check(dst_wr_addr == {bk, oa}, "R5 destination address", dst_wr_addr, {bk, oa});
        check(dst_wr_data[7:0] == pat(sa)[7:0] && dst_wr_data[15:8] == pat(sa)[15:8],
              "R8 byte lanes", dst_wr_data, pat(sa));
        done++;
      end
      cyc++;
      @(negedge clk);
    end
    src_ready = 1'b1;
    dst_ready = 1'b1;
    #1;
    check(!busy && !dst_wr_en, "R10 busy falls after last word", {busy, dst_wr_en}, 0);
  endtask

  task automatic load_ptrs(input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    src_ptr_we = 1'b1; src_ptr_wdata = s;
    dst_ptr_we = 1'b1; dst_ptr_wdata = d;
    @(negedge clk);
    src_ptr_we = 1'b0; dst_ptr_we = 1'b0;
    check(src_ptr == s && dst_ptr == d, "R12 host load", {src_ptr, dst_ptr}, {s, d});
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && src_ptr == 0 && dst_ptr == 0 && !src_rd_en && !dst_wr_en,
          "R1 reset state", {busy, src_ptr, dst_ptr}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] es, ed;
      load_ptrs(V_SRC[v], V_DST[v]);
      bank_sel = V_BNK[v];
      start = 1'b1; word_cnt = V_CNT[v];
      src_ready = 1'b0; dst_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      bank_sel = ~V_BNK[v]; // R3: live bank change must not matter
      es = V_SRC[v] + (V_CNT[v] * 2);
      ed = V_DST[v] + (V_CNT[v] / 2);
      check(src_ptr == es, "R6 source pointer step", src_ptr, es);
      check(dst_ptr == ed, "R7 destination register step", dst_ptr, ed);
      check(busy == (V_CNT[v] != 0), "R10 busy after start", busy, V_CNT[v] != 0);
      // R2 / R3: first addresses from masked pointers
      run_words(V_SRC[v][13:0] & 14'h3FFE, {V_DST[v][9:0], 2'b00}, V_BNK[v],
                int'(V_CNT[v]), V_SM[v], V_DM[v]);
    end

    // R11: start while busy is ignored
    load_ptrs(16'h0100, 16'h0010);
    bank_sel = 4'h2; start = 1'b1; word_cnt = 16'd4;
    src_ready = 1'b0; dst_ready = 1'b0;
    @(negedge clk);
    word_cnt = 16'd7;
    @(negedge clk);
    start = 1'b0;
    check(src_ptr == 16'h0108 && dst_ptr == 16'h0012, "R11 start while busy ignored",
          {src_ptr, dst_ptr}, {16'h0108, 16'h0012});
    check(busy, "R11 transfer still running", busy, 1);
    run_words(14'h0100, 12'h040, 4'h2, 4, 8'h00, 8'h00);

    // R12: start wins over a host write in the same cycle
    @(negedge clk);
    src_ptr_we = 1'b1; src_ptr_wdata = 16'h7777;
    dst_ptr_we = 1'b1; dst_ptr_wdata = 16'h5555;
    start = 1'b1; word_cnt = 16'd2; bank_sel = 4'hA;
    @(negedge clk);
    src_ptr_we = 1'b0; dst_ptr_we = 1'b0; start = 1'b0;
    check(src_ptr == 16'h010C && dst_ptr == 16'h0013, "R12 start precedence",
          {src_ptr, dst_ptr}, {16'h010C, 16'h0013});
    run_words(14'h0108, 12'h048, 4'hA, 2, 8'h00, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule